// File: doc/BRIEF.md
# Falling-Edge Event Counter Bank with Read Snapshots

The block counts events on a set of asynchronous digital inputs. Each input gets its own free-running counter, which steps on every high-to-low transition of that input once it has been brought into the clock domain. Because the counters run all the time, a host never reads them directly. Each counter has a holding register, and that register takes a copy of the live count at the moment the host raises that counter's read strobe. The host then reads a value that stays put while counting goes on.

There is no software clear. Every counter runs to all-ones and then starts again at zero, so the host works out event totals as modular differences between snapshots. A small status word shows the synchronized level of every input. Next to those levels it holds one general-purpose output bit that the host can write, and that bit also drives an output pin.

Top module: `edge_cnt_bank`

## Requirements
- R1: With default parameters there are four 16-bit counters. Counter i only ever responds to `pin_in[i]` and its own strobe `rd_stb[i]`. Activity on other inputs never changes it.
- R2: Each input passes through a two-flop synchronizer. A counter goes up by exactly one each time its synchronized level goes from 1 to 0, and a rising transition never changes it. With each pin held low for one clock and then high for one clock, every such pulse is counted.
- R3: On the clock edge where `rd_stb[i]` is first seen high after being low, `cnt_snap[i*16 +: 16]` loads the live count. The snapshot then holds until the next low-to-high transition of that strobe, including while the strobe stays high.
- R4: A counter holding 0xFFFF moves to 0x0000 on its next falling edge, and no input other than reset sets a counter back to zero.
- R5: `io_status[3:0]` shows the synchronized levels of `pin_in[3:0]` two clocks after a pin change. `io_status[4]` and `out_pin` show the output bit, which takes `out_wr_data` on the clock after a cycle with `out_wr_en` high.
- R6: A falling edge whose count step lands on the same clock edge as a capture is not lost. The snapshot taken on that edge holds the count from before the step, and the next snapshot includes it.
- R7: While `rst_n` is low, every counter, snapshot, synchronizer flop and the output bit are zero. An input that is already high when reset is released adds no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Asynchronous digital inputs, one per counter |
| rd_stb | input | 4 | Per-counter read strobes; low-to-high starts a capture |
| out_wr_en | input | 1 | Write enable for the output bit |
| out_wr_data | input | 1 | Value to write into the output bit |
| cnt_snap | output | 64 | Snapshots, counter i in bits i*16 +: 16 |
| io_status | output | 5 | {output bit, synchronized input levels [3:0]} |
| out_pin | output | 1 | Output bit driven off-block |

## Verification
Counts, captures, levels and the output bit each appear a fixed number of clocks after the stimulus that causes them. A pin that falls before edge E0 reaches the second synchronizer flop at E1, and the count steps at E2. A strobe that is first seen high at edge E loads the snapshot at E. A level appears on the status word at E1, and an output-bit write shows up on the edge that samples the enable. The bench drives every input on falling clock edges and reads results on a later falling edge. Before any snapshot read it waits at least four clocks after the last pin edge, except in the same-edge test. That test drives the pin and the strobe exactly two falling edges apart, so the count step and the capture fall on the same rising edge.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
    localparam int unsigned ECB_NUM_IN  = 4;
    localparam int unsigned ECB_CNT_W   = 16;
    localparam int unsigned ECB_SYNC_FF = 2;

    typedef struct packed {
        logic bit_val;
    } out_state_t;
endpackage

// File: rtl/ecb_fall_sync.sv
module ecb_fall_sync #(
    parameter int unsigned SYNC_FF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);
    localparam int unsigned CHAIN_W = SYNC_FF + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // chain[SYNC_FF-1] is the synchronized level, chain[SYNC_FF] its previous value
    assign level = st_q.chain[SYNC_FF-1];
    assign fall  = st_q.chain[SYNC_FF] & ~st_q.chain[SYNC_FF-1];
endmodule

// File: rtl/ecb_snap_counter.sv
module ecb_snap_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             stb,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] snap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             stb_prev;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb;
        if (step) begin
            st_d.cnt = st_q.cnt + ONE;   // wraps modulo 2**CNT_W
        end
        if (stb && !st_q.stb_prev) begin
            st_d.hold = st_q.cnt;        // pre-step value on a coinciding edge
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live = st_q.cnt;
    assign snap = st_q.hold;
endmodule

// File: rtl/ecb_out_bit.sv
module ecb_out_bit
    import ecb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    output logic val
);
    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.bit_val = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.bit_val;
endmodule

// File: rtl/edge_cnt_bank.sv
module edge_cnt_bank
    import ecb_pkg::*;
#(
    parameter int unsigned NUM_IN  = ECB_NUM_IN,
    parameter int unsigned CNT_W   = ECB_CNT_W,
    parameter int unsigned SYNC_FF = ECB_SYNC_FF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_IN-1:0]       pin_in,
    input  logic [NUM_IN-1:0]       rd_stb,
    input  logic                    out_wr_en,
    input  logic                    out_wr_data,
    output logic [NUM_IN*CNT_W-1:0] cnt_snap,
    output logic [NUM_IN:0]         io_status,
    output logic                    out_pin
);
    localparam int unsigned BUS_W = NUM_IN * CNT_W;

    logic [NUM_IN-1:0] lvl;
    logic [NUM_IN-1:0] fall;
    logic [BUS_W-1:0]  cnt_live;
    logic              obit;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_ch
        ecb_fall_sync #(.SYNC_FF(SYNC_FF)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[i]),
            .level (lvl[i]),
            .fall  (fall[i])
        );

        ecb_snap_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (fall[i]),
            .stb   (rd_stb[i]),
            .live  (cnt_live[i*CNT_W +: CNT_W]),
            .snap  (cnt_snap[i*CNT_W +: CNT_W])
        );
    end

    ecb_out_bit u_obit (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (out_wr_en),
        .wr_data (out_wr_data),
        .val     (obit)
    );

    assign io_status = {obit, lvl};
    assign out_pin   = obit;
endmodule

// File: rtl/edge_cnt_bank_chk.sv
module edge_cnt_bank_chk #(
    parameter int unsigned NUM_IN = 4,
    parameter int unsigned CNT_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_IN-1:0]       rd_stb,
    input logic                    out_wr_en,
    input logic                    out_wr_data,
    input logic [NUM_IN*CNT_W-1:0] cnt_snap,
    input logic [NUM_IN*CNT_W-1:0] cnt_live,
    input logic [NUM_IN:0]         io_status,
    input logic                    out_pin
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
        // R2 / R4: a live count either holds or moves up by one, modulo 2**CNT_W
        assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_live[i*CNT_W +: CNT_W] != $past(cnt_live[i*CNT_W +: CNT_W])) |->
            (cnt_live[i*CNT_W +: CNT_W] == $past(cnt_live[i*CNT_W +: CNT_W]) + ONE));

        // R3: a strobe seen low cannot change the snapshot on the next edge
        assert_snap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_stb[i] |=> $stable(cnt_snap[i*CNT_W +: CNT_W]));

        // R3: a strobe held high does not recapture
        assert_snap_held_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stb[i] && $past(rd_stb[i])) |=> $stable(cnt_snap[i*CNT_W +: CNT_W]));

        // R6: a capture loads the count as it stood before that edge
        assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stb[i] && !$past(rd_stb[i])) |=>
            (cnt_snap[i*CNT_W +: CNT_W] == $past(cnt_live[i*CNT_W +: CNT_W])));
    end

    // R5: output bit follows a write on the next edge
    assert_out_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |=> (out_pin == $past(out_wr_data)));

    // R5: without a write the output bit holds
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_wr_en |=> $stable(out_pin));

    // R5: status top bit and output pin agree
    assert_out_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        io_status[NUM_IN] == out_pin);
endmodule

bind edge_cnt_bank edge_cnt_bank_chk #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_stb      (rd_stb),
    .out_wr_en   (out_wr_en),
    .out_wr_data (out_wr_data),
    .cnt_snap    (cnt_snap),
    .cnt_live    (cnt_live),
    .io_status   (io_status),
    .out_pin     (out_pin)
);

// File: tb/sim_edge_cnt_bank.sv
`timescale 1ns/1ps
module sim_edge_cnt_bank;
    localparam int NI = 4;
    localparam int CW = 16;
    localparam int NV = 4;
    // each word: [63:32] expected cumulative counts (8 bits per channel), [31:0] pulses per channel
    localparam logic [63:0] VEC [NV] = '{
        64'h00_03_02_01__00_03_02_01,
        64'h05_03_03_01__05_00_01_00,
        64'h06_05_03_05__01_02_00_04,
        64'h08_07_05_07__02_02_02_02
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NI-1:0]     pin_in = '1;
    logic [NI-1:0]     rd_stb = '0;
    logic              out_wr_en = 1'b0;
    logic              out_wr_data = 1'b0;
    logic [NI*CW-1:0]  cnt_snap;
    logic [NI:0]       io_status;
    logic              out_pin;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    logic done = 1'b0;
    logic [CW-1:0] exp_cnt [NI];

    always #10 clk = ~clk;   // 50 MHz

    edge_cnt_bank u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rd_stb(rd_stb),
        .out_wr_en(out_wr_en), .out_wr_data(out_wr_data),
        .cnt_snap(cnt_snap), .io_status(io_status), .out_pin(out_pin)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] snap_of(input int ch);
        return cnt_snap[ch*CW +: CW];
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(input logic [31:0] n);
        int mx = 0;
        for (int c = 0; c < NI; c++) if (int'(n[c*8 +: 8]) > mx) mx = int'(n[c*8 +: 8]);
        for (int p = 0; p < mx; p++) begin
            @(negedge clk);
            for (int c = 0; c < NI; c++) if (p < int'(n[c*8 +: 8])) begin
                pin_in[c] = 1'b0;
                exp_cnt[c] = exp_cnt[c] + 1'b1;
            end
            @(negedge clk); @(negedge clk);
            pin_in = '1;
            @(negedge clk); @(negedge clk);
        end
        settle();
    endtask

    task automatic fast(input int ch, input int n);
        for (int p = 0; p < n; p++) begin
            @(negedge clk) pin_in[ch] = 1'b0;
            @(negedge clk) pin_in[ch] = 1'b1;
            exp_cnt[ch] = exp_cnt[ch] + 1'b1;
        end
        settle();
    endtask

    task automatic read_all();
        @(negedge clk) rd_stb = '1;
        @(negedge clk) rd_stb = '0;
    endtask

    initial begin
        for (int c = 0; c < NI; c++) exp_cnt[c] = '0;
        repeat (3) @(negedge clk);
        // R7: reset state while reset is held
        check("R7 snap reset", cnt_snap[31:0], 32'h0);
        check("R7 snap reset hi", cnt_snap[63:32], 32'h0);
        check("R7 status reset", 32'(io_status), 32'h0);
        rst_n = 1'b1;
        settle();
        read_all();
        check("R7 high pin at release not counted", cnt_snap[31:0], 32'h0);
        check("R5 levels high", 32'(io_status), 32'h0f);

        // R1 R2 R3: vector walk
        for (int v = 0; v < NV; v++) begin
            pulses(VEC[v][31:0]);
            read_all();
            for (int c = 0; c < NI; c++)
                check("R1 R2 table count", 32'(snap_of(c)), 32'(VEC[v][32 + c*8 +: 8]));
        end

        // R3: snapshot holds without a strobe
        fast(0, 3);
        check("R3 no strobe no change", 32'(snap_of(0)), 32'h7);
        read_all();
        check("R3 restrobe", 32'(snap_of(0)), 32'(exp_cnt[0]));

        // R3: strobe held high does not recapture
        @(negedge clk) rd_stb[1] = 1'b1;
        @(negedge clk);
        check("R3 held capture", 32'(snap_of(1)), 32'h5);
        fast(1, 3);
        check("R3 held high keeps snapshot", 32'(snap_of(1)), 32'h5);
        rd_stb[1] = 1'b0;
        read_all();
        check("R3 after release", 32'(snap_of(1)), 32'h8);

        // R6: step and capture on the same edge
        @(negedge clk) pin_in[3] = 1'b0;
        @(negedge clk);
        @(negedge clk) rd_stb[3] = 1'b1;
        @(negedge clk) rd_stb[3] = 1'b0;
        check("R6 same-edge snapshot old", 32'(snap_of(3)), 32'(exp_cnt[3]));
        exp_cnt[3] = exp_cnt[3] + 1'b1;
        pin_in[3] = 1'b1;
        settle();
        read_all();
        check("R6 next snapshot new", 32'(snap_of(3)), 32'(exp_cnt[3]));

        // R5: levels after two clocks, output bit
        @(negedge clk) pin_in = 4'b1010;
        exp_cnt[0] = exp_cnt[0] + 1'b1;
        exp_cnt[2] = exp_cnt[2] + 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R5 level latency", 32'(io_status[3:0]), 32'ha);
        out_wr_en = 1'b1; out_wr_data = 1'b1;
        @(negedge clk) out_wr_en = 1'b0; out_wr_data = 1'b0;
        check("R5 out bit set", 32'({io_status[4], out_pin}), 32'h3);
        @(negedge clk);
        check("R5 out bit holds", 32'(out_pin), 32'h1);
        pin_in = '1;
        settle();
        read_all();
        check("R1 ch0 only own input", 32'(snap_of(0)), 32'(exp_cnt[0]));
        check("R1 ch1 untouched", 32'(snap_of(1)), 32'(exp_cnt[1]));

        // R4: wrap on channel 2
        fast(2, 65535 - int'(exp_cnt[2]));
        read_all();
        check("R4 at max", 32'(snap_of(2)), 32'hffff);
        fast(2, 1);
        read_all();
        check("R4 wrap to zero", 32'(snap_of(2)), 32'h0);
        check("R1 ch3 unaffected by ch2", 32'(snap_of(3)), 32'(exp_cnt[3]));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule